// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. Software writes an 8-bit control word and a channel number. The block then walks each conversion through two phases. In the sampling phase the sample-and-hold output is low and the input is tracked. In the compare phase the input is held and the block drives a trial code to an external DAC. It reads one comparator bit back for each trial and settles one result bit per cycle, starting at the MSB.

After the last bit, the code goes into a result register and an end-of-conversion pulse is raised. Conversions repeat back to back for as long as the start bit stays set.

The comparator needs time to settle after it is switched on, so a start is held back for a fixed number of clocks after the enable bit rises. Clearing start, dropping the enable bit or writing a new channel abandons the conversion in flight. The result register is left untouched and no pulse is raised. Only the parts that decide the comparator's voltages lie outside the block: the DAC, the comparator and the hold circuit.

Top module: `sar_seq`

## Requirements
- R1: While and after reset, `busy`, `sample_hold` and `eoc_irq` are 0, and `result` is 0.
- R2: The control word uses bit 7 as start, bit 0 as comparator enable and bits 5:1 as the sample-time select. A conversion begins only while start and enable are both 1. When enable goes from 0 to 1 in a write that also sets start, `busy` rises exactly `SETTLE_CYC` clocks after that write edge. If enable has already been 1 for that long, `busy` rises one clock after the write that sets start.
- R3: Each conversion opens with a sampling phase of exactly `SAMP_BASE` + select clocks. During this phase `busy` is 1 and `sample_hold` is 0.
- R4: Sampling is followed by exactly `N_BITS` compare clocks with `sample_hold` at 1. The first trial code is the MSB alone (0x200 for 10 bits).
- R5: In each compare clock the bit under test stays 1 when `cmp_in` is 1 (input at or above the trial level) and is cleared otherwise. The next lower bit is then set to 1. With an ideal comparator, the result equals the input level.
- R6: The finished code appears on `result` at the same edge as a one-clock `eoc_irq` pulse. `result` changes at no other time, and `result_hi` is `result[9:2]`.
- R7: While start stays 1, a new sampling phase follows each result without a gap: `busy` stays 1 in the clock of the pulse.
- R8: Clearing start, or clearing enable, during a conversion drops `busy` within two clocks. No pulse follows and `result` is left unchanged.
- R9: A channel write during a conversion abandons it without a result. `chan_sel` takes the new value. The next conversion starts with a full sampling phase and reports the new channel's level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 8 | Control word: [7] start, [5:1] sample select, [0] comparator enable |
| chan_wr | input | 1 | Write strobe for the channel number |
| chan_wdata | input | CH_W | New channel number |
| cmp_in | input | 1 | Comparator decision: 1 when the held input is at or above the trial level |
| chan_sel | output | CH_W | Selected input channel, driving the analog mux |
| dac_code | output | N_BITS | Trial code for the DAC |
| sample_hold | output | 1 | 0 = sampling, 1 = holding for comparisons |
| busy | output | 1 | High from the start of sampling until the result is latched |
| result | output | N_BITS | Last completed conversion |
| result_hi | output | 8 | Upper eight bits of the result |
| eoc_irq | output | 1 | One-clock end-of-conversion pulse |

## Verification
The hardest case to reach is an abort that lands in the middle of the compare phase, where a faulty design would still complete and report a stale code. The bench waits until `sample_hold` has been high for a few clocks and then writes a new channel, or clears start. It gives the old and new channels different levels in its comparator model. The first pulse after the abort must therefore carry the new channel's level, and its sampling phase must have full length. The settling hold-off is measured by counting edges from the enabling write to the rise of `busy`.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_CONV   = 2'd2
    } seq_state_e;

    // Control word layout: bit 7 start, bit 6 unused, bits 5:1 sample select, bit 0 enable
    typedef struct packed {
        logic       start;
        logic       unused;
        logic [4:0] tsel;
        logic       cmp_en;
    } ctrl_t;

    localparam int unsigned CTRL_W = 8;

    function automatic ctrl_t decode_ctrl(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c        = ctrl_t'(w);
        c.unused = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/sar_settle.sv
module sar_settle #(
    parameter int unsigned SETTLE_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic en_next,
    output logic settled
);
    localparam int unsigned CW = $clog2(SETTLE_CYC + 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_next) begin
            cnt_q <= CW'(SETTLE_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign settled = (cnt_q == '0);
endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_seq_pkg::*;
#(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             abort,
    input  logic [CNT_W-1:0] samp_len,
    input  logic             last_bit,
    output seq_state_e       state,
    output logic             load,
    output logic             step,
    output logic             done
);
    seq_state_e       st_q;
    logic [CNT_W-1:0] scnt_q;

    assign load = (st_q == ST_SAMPLE) && (scnt_q == '0) && !abort;
    assign step = (st_q == ST_CONV);
    assign done = (st_q == ST_CONV) && last_bit && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            scnt_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (go) begin
                        st_q   <= ST_SAMPLE;
                        scnt_q <= samp_len - 1'b1;
                    end
                end
                ST_SAMPLE: begin
                    if (abort)              st_q   <= ST_IDLE;
                    else if (scnt_q == '0)  st_q   <= ST_CONV;
                    else                    scnt_q <= scnt_q - 1'b1;
                end
                ST_CONV: begin
                    if (abort) begin
                        st_q <= ST_IDLE;
                    end else if (last_bit) begin
                        if (go) begin
                            st_q   <= ST_SAMPLE;
                            scnt_q <= samp_len - 1'b1;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign state = st_q;
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
    parameter int unsigned N_BITS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              done,
    input  logic              cmp_in,
    output logic [N_BITS-1:0] code,
    output logic [N_BITS-1:0] result,
    output logic              last_bit
);
    localparam int unsigned IW = $clog2(N_BITS);

    logic [N_BITS-1:0] sar_q, sar_nx, res_q;
    logic [IW-1:0]     idx_q;

    always_comb begin
        sar_nx = sar_q;
        if (!cmp_in) sar_nx[idx_q] = 1'b0;
        if (idx_q != '0) sar_nx[idx_q - 1'b1] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sar_q <= '0;
            idx_q <= '0;
            res_q <= '0;
        end else begin
            if (load) begin
                sar_q <= {1'b1, {(N_BITS-1){1'b0}}};
                idx_q <= IW'(N_BITS - 1);
            end else if (step) begin
                sar_q <= sar_nx;
                if (idx_q != '0) idx_q <= idx_q - 1'b1;
            end
            if (done) res_q <= sar_nx;
        end
    end

    assign code     = sar_q;
    assign result   = res_q;
    assign last_bit = (idx_q == '0);
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_seq_pkg::*;
#(
    parameter int unsigned N_BITS     = 10,
    parameter int unsigned CH_W       = 3,
    parameter int unsigned SETTLE_CYC = 100,
    parameter int unsigned SAMP_BASE  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [7:0]        ctrl_wdata,
    input  logic              chan_wr,
    input  logic [CH_W-1:0]   chan_wdata,
    input  logic              cmp_in,
    output logic [CH_W-1:0]   chan_sel,
    output logic [N_BITS-1:0] dac_code,
    output logic              sample_hold,
    output logic              busy,
    output logic [N_BITS-1:0] result,
    output logic [7:0]        result_hi,
    output logic              eoc_irq
);
    localparam int unsigned CNT_W = $clog2(SAMP_BASE + 32);

    ctrl_t            ctrl_q;
    logic [CH_W-1:0]  chan_q;
    logic             en_next, settled, go, abort;
    logic             start_q, en_q;
    logic [CNT_W-1:0] samp_len;
    seq_state_e       state;
    logic             load, step, done, last_bit, eoc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            chan_q <= '0;
            eoc_q  <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= decode_ctrl(ctrl_wdata);
            if (chan_wr) chan_q <= chan_wdata;
            eoc_q <= done;
        end
    end

    assign start_q  = ctrl_q.start;
    assign en_q     = ctrl_q.cmp_en;
    assign en_next  = ctrl_wr ? ctrl_wdata[0] : en_q;
    assign go       = start_q && en_q && settled;
    assign abort    = chan_wr || !start_q || !en_q;
    assign samp_len = CNT_W'(SAMP_BASE) + CNT_W'(ctrl_q.tsel);

    sar_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .en_next (en_next),
        .settled (settled)
    );

    sar_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .abort    (abort),
        .samp_len (samp_len),
        .last_bit (last_bit),
        .state    (state),
        .load     (load),
        .step     (step),
        .done     (done)
    );

    sar_approx #(.N_BITS(N_BITS)) u_approx (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .done     (done),
        .cmp_in   (cmp_in),
        .code     (dac_code),
        .result   (result),
        .last_bit (last_bit)
    );

    assign chan_sel    = chan_q;
    assign busy        = (state != ST_IDLE);
    assign sample_hold = (state == ST_CONV);
    assign eoc_irq     = eoc_q;
    assign result_hi   = result[N_BITS-1 -: 8];
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int unsigned N_BITS = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              sample_hold,
    input logic              eoc_irq,
    input logic              start_q,
    input logic              en_q,
    input logic [N_BITS-1:0] dac_code,
    input logic [N_BITS-1:0] result
);
    // R2: sampling only begins after start and enable were both set
    a_r2_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_q && en_q));

    // R4: the first trial of every compare phase is the MSB alone
    a_r4_first_trial: assert property (@(posedge clk) disable iff (rst)
        $rose(sample_hold) |-> (dac_code == {1'b1, {(N_BITS-1){1'b0}}}));

    // R5: a trial code always carries the bit under test
    a_r5_trial_nonzero: assert property (@(posedge clk) disable iff (rst)
        sample_hold |-> (dac_code != '0));

    // R3: holding only happens inside a busy conversion
    a_r3_hold_in_busy: assert property (@(posedge clk) disable iff (rst)
        sample_hold |-> busy);

    // R6: the end pulse lasts one clock
    a_r6_eoc_single: assert property (@(posedge clk) disable iff (rst)
        eoc_irq |=> !eoc_irq);

    // R6: the result only moves together with the end pulse
    a_r6_result_with_eoc: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> eoc_irq);

    // R8: a cleared start ends the conversion on the next clock
    a_r8_stop_drops_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !start_q) |=> !busy);

    // R8: no end pulse is raised for a stopped conversion
    a_r8_no_eoc_when_stopped: assert property (@(posedge clk) disable iff (rst)
        eoc_irq |-> $past(start_q && en_q));
endmodule

bind sar_seq sar_seq_chk #(.N_BITS(N_BITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .sample_hold (sample_hold),
    .eoc_irq     (eoc_irq),
    .start_q     (start_q),
    .en_q        (en_q),
    .dac_code    (dac_code),
    .result      (result)
);

// File: tb/sar_seq_tb.sv
`timescale 1ns/1ps
module sar_seq_tb;
    localparam int N_BITS = 10;
    localparam int CH_W   = 3;
    localparam int SETTLE = 100;
    localparam int SBASE  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ctrl_wr = 1'b0;
    logic [7:0]        ctrl_wdata = '0;
    logic              chan_wr = 1'b0;
    logic [CH_W-1:0]   chan_wdata = '0;
    logic              cmp_in;
    logic [CH_W-1:0]   chan_sel;
    logic [N_BITS-1:0] dac_code, result;
    logic              sample_hold, busy, eoc_irq;
    logic [7:0]        result_hi;

    logic [N_BITS-1:0] vin [8];

    int checks = 0, errors = 0;
    int s_cnt = 0, c_cnt = 0, last_s = 0, last_c = 0, eoc_n = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    // Behavioural comparator: input at or above trial level gives 1
    assign cmp_in = (vin[chan_sel] >= dac_code);

    sar_seq #(.N_BITS(N_BITS), .CH_W(CH_W), .SETTLE_CYC(SETTLE), .SAMP_BASE(SBASE)) u_dut (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .chan_wr(chan_wr), .chan_wdata(chan_wdata), .cmp_in(cmp_in),
        .chan_sel(chan_sel), .dac_code(dac_code), .sample_hold(sample_hold),
        .busy(busy), .result(result), .result_hi(result_hi), .eoc_irq(eoc_irq)
    );

    // Phase-length monitor
    always @(negedge clk) begin
        if (rst) begin
            s_cnt = 0; c_cnt = 0;
        end else begin
            if (eoc_irq) begin
                last_s = s_cnt; last_c = c_cnt; s_cnt = 0; c_cnt = 0; eoc_n++;
            end
            if (!busy) begin
                s_cnt = 0; c_cnt = 0;
            end else if (!sample_hold) s_cnt++;
            else c_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic wr_ctrl(input bit st, input bit en, input logic [4:0] ts);
        tick();
        ctrl_wdata = {st, 1'b0, ts, en};
        ctrl_wr = 1'b1;
        @(posedge clk); #1;
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_chan(input logic [CH_W-1:0] ch);
        chan_wdata = ch;
        chan_wr = 1'b1;
        @(posedge clk); #1;
        chan_wr = 1'b0;
    endtask

    task automatic edges_to_busy(output int n);
        n = 0;
        while (!busy && n < 1000) begin
            @(posedge clk); #1; n++;
        end
    endtask

    task automatic wait_eoc();
        int k = 0;
        while (!eoc_irq && k < 3000) begin tick(); k++; end
        if (!eoc_irq) check(0, "eoc timeout", 0, 1);
    endtask

    task automatic wait_hold(input int extra);
        int k = 0;
        while (!sample_hold && k < 3000) begin tick(); k++; end
        repeat (extra) tick();
    endtask

    task automatic t_reset();
        tick();
        check(busy == 0 && sample_hold == 0 && eoc_irq == 0, "R1 flags in reset", int'({busy, sample_hold, eoc_irq}), 0);
        rst = 1'b0;
        tick();
        check(result == 0, "R1 result after reset", int'(result), 0);
        check(busy == 0, "R1 idle after reset", int'(busy), 0);
    endtask

    task automatic t_no_enable();
        bit seen = 0;
        wr_ctrl(1'b1, 1'b0, 5'd0);
        for (int i = 0; i < 150; i++) begin tick(); if (busy) seen = 1; end
        check(!seen, "R2 no conversion without enable", int'(seen), 0);
        wr_ctrl(1'b0, 1'b0, 5'd0);
    endtask

    task automatic t_settle_first();
        int n;
        vin[0] = 10'd300;
        wr_ctrl(1'b1, 1'b1, 5'd3);
        edges_to_busy(n);
        check(n == SETTLE, "R2 settle delay", n, SETTLE);
        wait_eoc();
        check(result == 10'd300, "R5 first result", int'(result), 300);
        check(result_hi == 8'd75, "R6 high byte", int'(result_hi), 75);
        check(last_s == SBASE + 3, "R3 sample length", last_s, SBASE + 3);
        check(last_c == N_BITS, "R4 compare length", last_c, N_BITS);
        tick();
        check(eoc_irq == 0, "R6 pulse width", int'(eoc_irq), 0);
        check(busy == 1, "R7 back-to-back", int'(busy), 1);
    endtask

    task automatic t_levels();
        int lv [8] = '{0, 1023, 512, 511, 1, 341, 682, 1000};
        foreach (lv[i]) begin
            vin[0] = N_BITS'(lv[i]);
            wait_eoc();
            check(result == N_BITS'(lv[i]), "R5 level", int'(result), lv[i]);
            check(busy == 1, "R7 stays busy at pulse", int'(busy), 1);
            tick();
        end
    endtask

    task automatic t_tsel();
        wr_ctrl(1'b1, 1'b1, 5'd20);
        wait_eoc(); tick();
        wait_eoc();
        check(last_s == SBASE + 20, "R3 sample select 20", last_s, SBASE + 20);
    endtask

    task automatic t_stop();
        int e0;
        logic [N_BITS-1:0] keep;
        vin[0] = 10'd900;
        wait_hold(3);
        keep = result;
        wr_ctrl(1'b0, 1'b1, 5'd3);
        e0 = eoc_n;
        tick(); tick();
        check(busy == 0, "R8 stop drops busy", int'(busy), 0);
        repeat (40) tick();
        check(eoc_n == e0, "R8 no pulse after stop", eoc_n, e0);
        check(result == keep, "R8 result kept", int'(result), int'(keep));
    endtask

    task automatic t_restart_settled();
        int n;
        vin[0] = 10'd100;
        vin[5] = 10'd777;
        wr_ctrl(1'b1, 1'b1, 5'd3);
        edges_to_busy(n);
        check(n == 1, "R2 start when settled", n, 1);
    endtask

    task automatic t_chan_abort();
        int e0;
        wait_hold(2);
        e0 = eoc_n;
        wr_chan(3'd5);
        check(chan_sel == 3'd5, "R9 channel updated", int'(chan_sel), 5);
        wait_eoc();
        check(result == 10'd777, "R9 first result is new channel", int'(result), 777);
        check(eoc_n == e0 + 1, "R9 aborted conversion silent", eoc_n, e0 + 1);
        check(last_s == SBASE + 3, "R9 fresh sample phase", last_s, SBASE + 3);
        check(last_c == N_BITS, "R9 full compare phase", last_c, N_BITS);
    endtask

    task automatic t_disable();
        int n;
        wait_hold(1);
        wr_ctrl(1'b1, 1'b0, 5'd3);
        tick(); tick();
        check(busy == 0, "R8 disable drops busy", int'(busy), 0);
        wr_ctrl(1'b1, 1'b1, 5'd3);
        edges_to_busy(n);
        check(n == SETTLE, "R2 settle after re-enable", n, SETTLE);
    endtask

    initial begin
        foreach (vin[i]) vin[i] = '0;
        repeat (3) @(posedge clk);
        t_reset();
        t_no_enable();
        t_settle_first();
        t_levels();
        t_tsel();
        t_stop();
        t_restart_settled();
        t_chan_abort();
        t_disable();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule